// File: doc/BRIEF.md
# Bit-Weight Binary-to-BCD Converter

The block turns an unsigned binary operand into packed BCD digits. It does not shift and adjust. It tests the operand one bit per clock, starting at the most significant bit. For each set bit it adds the decimal value of that bit's weight, for example 128 for bit 7 or 32768 for bit 15, into a BCD accumulator. The addition runs digit by digit, and a decimal carry passes from each digit to the next. A clear bit leaves the accumulator as it is. The weight table is built at elaboration time from the `DATA_W` parameter, which is 8 or 16. The number of output digits is derived from `DATA_W`: three digits for 8 bits and five digits for 16 bits.

A caller pulses `start` with the operand on `operand`. The block then spends `DATA_W` cycles scanning the bits and raises `done`. The digits stay on `bcd` until the next accepted start.

The controller has three states:
- IDLE: the state after reset. `start` moves it to SCAN.
- SCAN: one bit is processed per cycle. After bit 0 it moves to DONE.
- DONE: the result is held. `start` moves it back to SCAN.

Top module: `bw2bcd`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `bcd` is all zeros.
- R2: `start` is accepted in IDLE or DONE. On the next cycle `done` is 0 and `bcd` is all zeros.
- R3: When `done` is 1, `bcd` holds the decimal value of the accepted operand. Digit k (units = 0) sits in bits [4k+3:4k].
- R4: `done` rises exactly `DATA_W` clock edges after the edge that samples `start`. It stays 0 before that.
- R5: While `done` is 1 and `start` is low, `done` and `bcd` do not change, even if `operand` changes.
- R6: A `start` pulse during SCAN is ignored. The running conversion finishes with its original operand and its original timing.
- R7: Every BCD digit on `bcd` is in the range 0 to 9 at all times.
- R8: A cycle that processes a clear operand bit leaves `bcd` unchanged.
- R9: Bits are processed from most significant to least significant. One edge after the accepting edge, `bcd` equals the weight of the top bit if that bit is set.
- R10: The largest operand (255 for 8 bits, 65535 for 16 bits) converts without losing a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a conversion of `operand` (accepted in IDLE or DONE) |
| operand | input | DATA_W | Unsigned binary value to convert |
| done | output | 1 | Result on `bcd` is valid and held |
| bcd | output | 4*NDIG | Packed BCD digits, units digit in the low nibble |

## Verification
The bench drives `start` on a falling edge. It counts the rising edge that samples `start` as edge zero. `bcd` must read zero after edge zero. If the top bit is set, `bcd` must show that bit's weight after edge one. `done` must stay low through edge `DATA_W`-1 and read high with the final digits after edge `DATA_W`. All sampling happens on falling edges, so each check reads the registered outputs half a cycle after the edge that updated them. The held-result and ignored-start cases are checked the same way. The bench counts edges from a known acceptance edge and does not wait for `done` to appear.

// File: rtl/bw2bcd_pkg.sv
package bw2bcd_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } bw_state_e;

    // Number of decimal digits needed for the largest value of a width.
    function automatic int digits_for(input int width);
        longint m;
        int     n;
        m = (longint'(1) << width) - 1;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (m > 0) begin
                n++;
                m = m / 10;
            end
        end
        if (n == 0) n = 1;
        return n;
    endfunction

    // Decimal digit dig_i of the value 2**bit_i.
    function automatic logic [3:0] weight_digit(input int bit_i, input int dig_i);
        longint v;
        v = longint'(1) << bit_i;
        for (int k = 0; k < 20; k++) begin
            if (k < dig_i) v = v / 10;
        end
        return 4'(v % 10);
    endfunction

endpackage

// File: rtl/bw_weight_rom.sv
module bw_weight_rom
    import bw2bcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NDIG   = 3,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [4*NDIG-1:0] weight
);

    logic [DATA_W-1:0][4*NDIG-1:0] table_w;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        for (genvar d = 0; d < NDIG; d++) begin : g_dig
            assign table_w[b][4*d +: 4] = weight_digit(b, d);
        end
    end

    assign weight = table_w[idx];

endmodule

// File: rtl/bw_digit_add.sv
module bw_digit_add (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       cin,
    output logic [3:0] sum,
    output logic       cout
);

    logic [4:0] raw;

    always_comb begin
        raw  = 5'(a) + 5'(b) + 5'(cin);
        cout = (raw > 5'd9);
        sum  = cout ? 4'(raw - 5'd10) : raw[3:0];
    end

endmodule

// File: rtl/bw2bcd.sv
module bw2bcd
    import bw2bcd_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NDIG  = digits_for(DATA_W),
    localparam int BCD_W = 4 * NDIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              done,
    output logic [BCD_W-1:0]  bcd
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

    bw_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] opnd_q;
    logic [BCD_W-1:0]  acc_q;
    logic [BCD_W-1:0]  weight;
    logic [BCD_W-1:0]  sum_w;
    logic [NDIG:0]     carry;
    logic              bit_set;
    logic              accept;

    bw_weight_rom #(
        .DATA_W (DATA_W),
        .NDIG   (NDIG),
        .IDX_W  (IDX_W)
    ) u_rom (
        .idx    (idx_q),
        .weight (weight)
    );

    assign carry[0] = 1'b0;

    for (genvar d = 0; d < NDIG; d++) begin : g_add
        bw_digit_add u_dig (
            .a    (acc_q[4*d +: 4]),
            .b    (weight[4*d +: 4]),
            .cin  (carry[d]),
            .sum  (sum_w[4*d +: 4]),
            .cout (carry[d+1])
        );
    end

    assign bit_set = opnd_q[idx_q];
    assign accept  = start && (state_q != S_SCAN);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_SCAN;
            S_SCAN: if (idx_q == '0) state_d = S_DONE;
            S_DONE: if (start) state_d = S_SCAN;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= IDX_TOP;
            opnd_q <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            idx_q  <= IDX_TOP;
            opnd_q <= operand;
            acc_q  <= '0;
        end else if (state_q == S_SCAN) begin
            if (bit_set) acc_q <= sum_w;
            if (idx_q != '0) idx_q <= idx_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        done = (state_q == S_DONE);
        bcd  = acc_q;
    end

    // Assertions
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done && acc_q == '0 && state_q == S_SCAN));

    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && idx_q == '0) |=> done);

    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !start) |=> (done && $stable(bcd)));

    a_r6_scan_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && idx_q != '0) |=> ($stable(opnd_q) && state_q == S_SCAN));

    a_r8_clear_bit_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && !bit_set) |=> $stable(acc_q));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && bit_set) |-> !carry[NDIG]);

    for (genvar d = 0; d < NDIG; d++) begin : g_chk
        a_r7_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            acc_q[4*d +: 4] <= 4'd9);
    end

endmodule

// File: tb/bw2bcd_bench.sv
module bw2bcd_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start8 = 1'b0;
    logic [7:0]  op8 = '0;
    logic        done8;
    logic [11:0] bcd8;
    logic        start16 = 1'b0;
    logic [15:0] op16 = '0;
    logic        done16;
    logic [19:0] bcd16;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bw2bcd #(.DATA_W(8)) u_bw2bcd (
        .clk(clk), .rst_n(rst_n), .start(start8), .operand(op8),
        .done(done8), .bcd(bcd8)
    );

    bw2bcd #(.DATA_W(16)) u_bw2bcd_16 (
        .clk(clk), .rst_n(rst_n), .start(start16), .operand(op16),
        .done(done16), .bcd(bcd16)
    );

    function automatic logic [19:0] to_bcd(input int v);
        logic [19:0] r;
        int x;
        r = '0;
        x = v;
        for (int d = 0; d < 5; d++) begin
            r[4*d +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic logic [19:0] sel_bcd(input bit wide);
        return wide ? bcd16 : {8'h00, bcd8};
    endfunction

    function automatic logic sel_done(input bit wide);
        return wide ? done16 : done8;
    endfunction

    task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_start(input bit wide, input int v);
        @(negedge clk);
        if (wide) begin start16 = 1'b1; op16 = 16'(v); end
        else      begin start8  = 1'b1; op8  = 8'(v);  end
        @(negedge clk);
        start8  = 1'b0;
        start16 = 1'b0;
    endtask

    task automatic digits_ok(input bit wide, input string req);
        logic [19:0] b;
        b = sel_bcd(wide);
        for (int d = 0; d < 5; d++) chk(20'(b[4*d +: 4] <= 4'd9), 20'd1, req);
    endtask

    // One full conversion with latency check (R2, R3, R4, R7)
    task automatic convert(input bit wide, input int v);
        int w;
        w = wide ? 16 : 8;
        drive_start(wide, v);
        chk(20'(sel_done(wide)), 20'd0, "R2 done cleared");
        chk(sel_bcd(wide), 20'd0, "R2 acc cleared");
        for (int j = 1; j < w; j++) begin
            @(negedge clk);
            chk(20'(sel_done(wide)), 20'd0, "R4 done early");
        end
        @(negedge clk);
        chk(20'(sel_done(wide)), 20'd1, "R4 done due");
        chk(sel_bcd(wide), to_bcd(v), "R3 value");
    endtask

    task automatic t_reset;
        chk(20'(done8), 20'd0, "R1 done8");
        chk({8'h00, bcd8}, 20'd0, "R1 bcd8");
        chk(20'(done16), 20'd0, "R1 done16");
        chk(bcd16, 20'd0, "R1 bcd16");
    endtask

    task automatic t_exhaustive8;
        for (int v = 0; v < 256; v++) begin
            convert(1'b0, v);
            if (v == 99 || v == 199) digits_ok(1'b0, "R7 digit range");
        end
    endtask

    task automatic t_random16;
        for (int n = 0; n < 200; n++) begin
            convert(1'b1, int'($urandom() % 65536));
        end
        digits_ok(1'b1, "R7 digit range 16");
    endtask

    task automatic t_max;
        convert(1'b0, 255);
        chk({8'h00, bcd8}, 20'h00255, "R10 max 8");
        convert(1'b1, 65535);
        chk(bcd16, 20'h65535, "R10 max 16");
    endtask

    task automatic t_msb_first;
        drive_start(1'b0, 8'h81);
        @(negedge clk);
        chk({8'h00, bcd8}, 20'h00128, "R9 top bit first 8");
        repeat (7) @(negedge clk);
        chk({8'h00, bcd8}, 20'h00129, "R9 final 8");
        drive_start(1'b1, 16'h8001);
        @(negedge clk);
        chk(bcd16, 20'h32768, "R9 top bit first 16");
        repeat (15) @(negedge clk);
        chk(bcd16, 20'h32769, "R9 final 16");
    endtask

    task automatic t_clear_bits;
        drive_start(1'b0, 8'h40);
        @(negedge clk);
        chk({8'h00, bcd8}, 20'h0, "R8 bit7 clear");
        @(negedge clk);
        chk({8'h00, bcd8}, 20'h64, "R8 bit6 set");
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk({8'h00, bcd8}, 20'h64, "R8 low bits clear");
        end
    endtask

    task automatic t_hold;
        convert(1'b0, 173);
        op8 = 8'd5;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            op8 = 8'(j * 37);
            chk(20'(done8), 20'd1, "R5 done held");
            chk({8'h00, bcd8}, 20'h00173, "R5 value held");
        end
    endtask

    task automatic t_ignore_start;
        drive_start(1'b0, 200);
        @(negedge clk);
        start8 = 1'b1;
        op8 = 8'd55;
        @(negedge clk);
        start8 = 1'b0;
        for (int j = 3; j < 8; j++) begin
            @(negedge clk);
            chk(20'(done8), 20'd0, "R6 no restart");
        end
        @(negedge clk);
        chk(20'(done8), 20'd1, "R6 timing kept");
        chk({8'h00, bcd8}, 20'h00200, "R6 original operand");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exhaustive8();
        t_random16();
        t_max();
        t_msb_first();
        t_clear_bits();
        t_hold();
        t_ignore_start();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule